// File: doc/BRIEF.md
# Synchronous Serial Transmit Slot Controller

This block runs the transmit half of a frame-synchronised serial port. Host logic loads a 16-bit data holding register through a one-cycle write strobe. At the start of each transmit slot the block copies that word into a slot register and sends it most significant bit first, one bit per serial bit tick. A frame contains between one and sixteen slots. In normal mode only the first slot of a frame carries data. In network mode every slot carries data.

When a transmit slot begins and no fresh word is waiting, the block sets an underrun flag and sends the previous word again. While that flag is set, the transmit request goes to a separate exception interrupt line instead of the ordinary data-request line. The flag is cleared by a status read followed by a data write or a time-slot write. A time-slot write tells the block that the host has handled the next slot without supplying data. Serial clock generation, reception and DMA belong to other blocks.

Top module: `sertx_slot_ctrl`

## Requirements
- R1: Synchronous active-high reset drives these values: txd 0, stat_frame 0, stat_empty 1, stat_underrun 0, irq_data 0 and irq_exc 0.
- R2: A bit tick at bit position 0 of a slot starts that slot. From the edge of that tick, txd shows bit 15 of the slot's word. Each later tick moves txd to the next lower bit, and a slot spans 16 ticks.
- R3: At the start of a transmit slot, if the holding register holds an unsent word, that word is copied out and stat_empty goes to 1. A data write stores the word and clears stat_empty.
- R4: In normal mode (net_mode=0) only slot 0 is a transmit slot. In the other slots txd stays 0, no word is copied and no underrun is raised.
- R5: In network mode (net_mode=1) every slot is a transmit slot. A frame has slots_m1+1 slots, from 1 to 16.
- R6: If a transmit slot starts with stat_empty=1 and no pending time-slot write, stat_underrun goes to 1 and the previous slot word is sent again.
- R7: stat_underrun clears only on a data write or a time-slot write that follows a status read (rd_status_en) made since the previous write. A write with no such read leaves it set. A new underrun event takes priority over a clear in the same cycle.
- R8: A time-slot write marks the next transmit slot as serviced. That slot resends the previous word, raises no underrun and leaves stat_empty at 1.
- R9: irq_data is tx_en and stat_empty and not stat_underrun. irq_exc is tx_en and stat_empty and stat_underrun. Both are registered, and they are never high together.
- R10: stat_frame goes to 1 at the start of slot 0 and to 0 at the start of the next slot. With a single-slot frame it stays at 1.
- R11: While tx_en is 0, the position is held at slot 0, bit 0, txd is 0 and both interrupts are 0. The first tick after enabling starts slot 0.
- R12: A word written while stat_frame is 1 is sent in slot 1 in network mode, or in slot 0 of the next frame in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| net_mode | input | 1 | 1 = network mode, 0 = normal mode |
| slots_m1 | input | 4 | Slots per frame minus one |
| bit_tick | input | 1 | One-cycle strobe per serial bit |
| wr_data_en | input | 1 | Write strobe for the data holding register |
| wr_data | input | 16 | Word to transmit |
| wr_slot_en | input | 1 | Time-slot register write strobe |
| rd_status_en | input | 1 | Status read strobe |
| txd | output | 1 | Serial data out |
| stat_underrun | output | 1 | Underrun flag |
| stat_frame | output | 1 | Frame-sync (first slot) flag |
| stat_empty | output | 1 | Holding register empty flag |
| irq_data | output | 1 | Data-request interrupt |
| irq_exc | output | 1 | Underrun exception interrupt |

## Verification
The bench uses the default 16-bit word and 4-bit slot count. It holds bit_tick high so that each cycle is one bit, which lets the expected txd value be computed from the cycle index alone. It compares every transmitted bit across three-slot and single-slot network frames and four-slot normal frames. This covers the first-slot flag, data deferred to a later slot, idle normal-mode slots, underrun with resend, the read-then-write clear compared with a bare write, and a slot serviced through a time-slot write.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  parameter int unsigned SERTX_WORD_W = 16;
  parameter int unsigned SERTX_SLOT_W = 4;

  typedef struct packed {
    logic underrun;
    logic frame;
  } sertx_flags_t;
endpackage

// File: rtl/sertx_slot_timer.sv
module sertx_slot_timer #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SLOT_W = 4,
  localparam int unsigned BIT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              bit_tick,
  input  logic              net_mode,
  input  logic [SLOT_W-1:0] slots_m1,
  output logic              slot_start,
  output logic              tx_slot,
  output logic              first_slot,
  output logic [BIT_W-1:0]  bit_idx
);
  logic [BIT_W-1:0]  bit_cnt;
  logic [SLOT_W-1:0] slot_cnt;
  logic              last_bit;

  assign last_bit   = (bit_cnt == BIT_W'(WORD_W - 1));
  assign slot_start = tx_en && bit_tick && (bit_cnt == '0);
  assign first_slot = (slot_cnt == '0);
  assign tx_slot    = net_mode || first_slot;
  assign bit_idx    = bit_cnt;

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      bit_cnt  <= '0;
      slot_cnt <= '0;
    end else if (bit_tick) begin
      if (last_bit) begin
        bit_cnt  <= '0;
        slot_cnt <= (slot_cnt >= slots_m1) ? '0 : slot_cnt + 1'b1;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  a_r11_idle_home: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (bit_cnt == '0 && slot_cnt == '0));
  a_r2_bit_step: assert property (@(posedge clk) disable iff (rst)
    (tx_en && bit_tick && !last_bit) |=> (bit_cnt == BIT_W'($past(bit_cnt) + 1'b1)));
endmodule

// File: rtl/sertx_tx_datapath.sv
module sertx_tx_datapath #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned BIT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              bit_tick,
  input  logic              slot_start,
  input  logic              tx_slot,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              wr_data_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_slot_en,
  output logic              txd,
  output logic              data_empty,
  output logic              underrun_evt
);
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] cur_word;
  logic [WORD_W-1:0] shifted;
  logic              empty_q;
  logic              skip_q;
  logic              txd_q;
  logic              load;
  logic              slot_open;

  assign slot_open    = slot_start && tx_slot;
  assign load         = slot_open && !empty_q;
  assign underrun_evt = slot_open && empty_q && !skip_q;
  assign cur_word     = load ? hold_q : word_q;
  assign shifted      = cur_word << bit_idx;
  assign txd          = txd_q;
  assign data_empty   = empty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      word_q  <= '0;
      empty_q <= 1'b1;
      skip_q  <= 1'b0;
      txd_q   <= 1'b0;
    end else begin
      if (wr_data_en) hold_q <= wr_data;
      if (load) word_q <= hold_q;
      if (wr_data_en)  empty_q <= 1'b0;
      else if (load)   empty_q <= 1'b1;
      if (wr_slot_en)                 skip_q <= 1'b1;
      else if (slot_open && empty_q)  skip_q <= 1'b0;
      if (!tx_en)         txd_q <= 1'b0;
      else if (bit_tick)  txd_q <= tx_slot ? shifted[WORD_W-1] : 1'b0;
    end
  end

  a_r3_empty_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(empty_q) |-> $past(wr_data_en));
  a_r6_word_hold: assert property (@(posedge clk) disable iff (rst)
    !slot_start |=> $stable(word_q));
endmodule

// File: rtl/sertx_tx_status.sv
module sertx_tx_status
  import sertx_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         tx_en,
  input  logic         slot_start,
  input  logic         first_slot,
  input  logic         underrun_evt,
  input  logic         data_empty,
  input  logic         rd_status_en,
  input  logic         wr_data_en,
  input  logic         wr_slot_en,
  output sertx_flags_t flags,
  output logic         irq_data,
  output logic         irq_exc
);
  logic armed_q;
  logic ur_q;
  logic ur_nxt;
  logic frame_q;
  logic irq_data_q;
  logic irq_exc_q;
  logic any_wr;

  assign any_wr = wr_data_en || wr_slot_en;

  always_comb begin
    ur_nxt = ur_q;
    if (underrun_evt)          ur_nxt = 1'b1;
    else if (any_wr && armed_q) ur_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q    <= 1'b0;
      ur_q       <= 1'b0;
      frame_q    <= 1'b0;
      irq_data_q <= 1'b0;
      irq_exc_q  <= 1'b0;
    end else begin
      if (any_wr)            armed_q <= 1'b0;
      else if (rd_status_en) armed_q <= 1'b1;
      ur_q <= ur_nxt;
      if (!tx_en)          frame_q <= 1'b0;
      else if (slot_start) frame_q <= first_slot;
      irq_data_q <= tx_en && data_empty && !ur_nxt;
      irq_exc_q  <= tx_en && data_empty && ur_nxt;
    end
  end

  assign flags.underrun = ur_q;
  assign flags.frame    = frame_q;
  assign irq_data       = irq_data_q;
  assign irq_exc        = irq_exc_q;

  a_r9_irq_excl: assert property (@(posedge clk) disable iff (rst)
    !(irq_data_q && irq_exc_q));
  a_r7_clear_armed: assert property (@(posedge clk) disable iff (rst)
    $fell(ur_q) |-> $past(armed_q && any_wr));
endmodule

// File: rtl/sertx_slot_ctrl.sv
module sertx_slot_ctrl
  import sertx_pkg::*;
#(
  parameter int unsigned WORD_W = SERTX_WORD_W,
  parameter int unsigned SLOT_W = SERTX_SLOT_W,
  localparam int unsigned BIT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              net_mode,
  input  logic [SLOT_W-1:0] slots_m1,
  input  logic              bit_tick,
  input  logic              wr_data_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_slot_en,
  input  logic              rd_status_en,
  output logic              txd,
  output logic              stat_underrun,
  output logic              stat_frame,
  output logic              stat_empty,
  output logic              irq_data,
  output logic              irq_exc
);
  logic             slot_start;
  logic             tx_slot;
  logic             first_slot;
  logic [BIT_W-1:0] bit_idx;
  logic             underrun_evt;
  logic             data_empty;
  sertx_flags_t     flags;

  sertx_slot_timer #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_timer (
    .clk(clk), .rst(rst), .tx_en(tx_en), .bit_tick(bit_tick),
    .net_mode(net_mode), .slots_m1(slots_m1),
    .slot_start(slot_start), .tx_slot(tx_slot),
    .first_slot(first_slot), .bit_idx(bit_idx)
  );

  sertx_tx_datapath #(.WORD_W(WORD_W)) u_data (
    .clk(clk), .rst(rst), .tx_en(tx_en), .bit_tick(bit_tick),
    .slot_start(slot_start), .tx_slot(tx_slot), .bit_idx(bit_idx),
    .wr_data_en(wr_data_en), .wr_data(wr_data), .wr_slot_en(wr_slot_en),
    .txd(txd), .data_empty(data_empty), .underrun_evt(underrun_evt)
  );

  sertx_tx_status u_status (
    .clk(clk), .rst(rst), .tx_en(tx_en), .slot_start(slot_start),
    .first_slot(first_slot), .underrun_evt(underrun_evt),
    .data_empty(data_empty), .rd_status_en(rd_status_en),
    .wr_data_en(wr_data_en), .wr_slot_en(wr_slot_en),
    .flags(flags), .irq_data(irq_data), .irq_exc(irq_exc)
  );

  assign stat_underrun = flags.underrun;
  assign stat_frame    = flags.frame;
  assign stat_empty    = data_empty;

  a_r6_underrun_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_underrun) |-> $past(slot_start && tx_slot && data_empty));
  a_r4_idle_slot_quiet: assert property (@(posedge clk) disable iff (rst)
    (slot_start && !tx_slot) |=> (txd == 1'b0 && !$rose(stat_underrun)));
endmodule

// File: tb/sertx_slot_ctrl_bench.sv
`timescale 1ns/1ps
module sertx_slot_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_en = 1'b0;
  logic        net_mode = 1'b1;
  logic [3:0]  slots_m1 = 4'd2;
  logic        bit_tick = 1'b1;
  logic        wr_data_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_slot_en = 1'b0;
  logic        rd_status_en = 1'b0;
  logic        txd, stat_underrun, stat_frame, stat_empty, irq_data, irq_exc;
  int          n_vec = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  sertx_slot_ctrl u_sertx_slot_ctrl (
    .clk(clk), .rst(rst), .tx_en(tx_en), .net_mode(net_mode),
    .slots_m1(slots_m1), .bit_tick(bit_tick), .wr_data_en(wr_data_en),
    .wr_data(wr_data), .wr_slot_en(wr_slot_en), .rd_status_en(rd_status_en),
    .txd(txd), .stat_underrun(stat_underrun), .stat_frame(stat_frame),
    .stat_empty(stat_empty), .irq_data(irq_data), .irq_exc(irq_exc)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic e, input logic u,
                           input logic id, input logic ie);
    chk({req, " empty"}, {15'b0, stat_empty}, {15'b0, e});
    chk({req, " underrun"}, {15'b0, stat_underrun}, {15'b0, u});
    chk({req, " irq_data"}, {15'b0, irq_data}, {15'b0, id});
    chk({req, " irq_exc"}, {15'b0, irq_exc}, {15'b0, ie});
  endtask

  // op codes: 0 none, 1 data write, 2 status read, 3 time-slot write
  task automatic do_op(input int op, input logic [15:0] w);
    case (op)
      1: begin wr_data_en = 1'b1; wr_data = w; end
      2: rd_status_en = 1'b1;
      3: wr_slot_en = 1'b1;
      default: ;
    endcase
  endtask

  task automatic run_slot(input string req, input logic [15:0] exp_w, input logic active,
                          input logic exp_fs, input int op_a, input logic [15:0] wa,
                          input int op_b, input logic [15:0] wb);
    for (int j = 0; j < 16; j++) begin
      @(posedge clk); #1;
      wr_data_en = 1'b0; rd_status_en = 1'b0; wr_slot_en = 1'b0;
      chk(active ? {req, " R2 bit"} : {req, " R4 idle"}, {15'b0, txd},
          {15'b0, active ? exp_w[15 - j] : 1'b0});
      if (j == 0) chk({req, " R10 frame flag"}, {15'b0, stat_frame}, {15'b0, exp_fs});
      if (j == 3) do_op(op_a, wa);
      if (j == 7) do_op(op_b, wb);
    end
  endtask

  task automatic pulse(input int op, input logic [15:0] w);
    do_op(op, w);
    @(posedge clk); #1;
    wr_data_en = 1'b0; rd_status_en = 1'b0; wr_slot_en = 1'b0;
  endtask

  task automatic disable_tx();
    tx_en = 1'b0;
    @(posedge clk); #1;
    chk("R11 txd off", {15'b0, txd}, 16'h0);
    chk("R11 irq off", {14'b0, irq_data, irq_exc}, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk("R1 txd", {15'b0, txd}, 16'h0);
    chk("R1 frame", {15'b0, stat_frame}, 16'h0);
    chk_state("R1 reset", 1'b1, 1'b0, 1'b0, 1'b0);

    // network mode, three slots per frame (R5)
    net_mode = 1'b1; slots_m1 = 4'd2;
    pulse(1, 16'hA5C3);
    tx_en = 1'b1;
    run_slot("R5 net s0", 16'hA5C3, 1'b1, 1'b1, 1, 16'h3C96, 0, 16'h0);
    chk_state("R3 after write", 1'b0, 1'b0, 1'b0, 1'b0);
    run_slot("R12 net s1", 16'h3C96, 1'b1, 1'b0, 0, 16'h0, 0, 16'h0);
    chk_state("R3 loaded", 1'b1, 1'b0, 1'b1, 1'b0);
    run_slot("R6 resend s2", 16'h3C96, 1'b1, 1'b0, 0, 16'h0, 0, 16'h0);
    chk_state("R6 underrun", 1'b1, 1'b1, 1'b0, 1'b1);
    run_slot("R7 bare write", 16'h3C96, 1'b1, 1'b1, 1, 16'h0F1E, 0, 16'h0);
    chk_state("R7 no read keeps flag", 1'b0, 1'b1, 1'b0, 1'b0);
    run_slot("R7 read+write", 16'h0F1E, 1'b1, 1'b0, 2, 16'h0, 1, 16'hE281);
    chk_state("R7 cleared", 1'b0, 1'b0, 1'b0, 1'b0);
    run_slot("R8 slot write", 16'hE281, 1'b1, 1'b0, 3, 16'h0, 0, 16'h0);
    chk_state("R8 pending", 1'b1, 1'b0, 1'b1, 1'b0);
    run_slot("R8 serviced", 16'hE281, 1'b1, 1'b1, 0, 16'h0, 0, 16'h0);
    chk_state("R8 no underrun", 1'b1, 1'b0, 1'b1, 1'b0);
    disable_tx();

    // normal mode, four slots per frame (R4)
    net_mode = 1'b0; slots_m1 = 4'd3;
    pulse(1, 16'h9D42);
    tx_en = 1'b1;
    run_slot("R4 norm f1s0", 16'h9D42, 1'b1, 1'b1, 1, 16'h5B77, 0, 16'h0);
    for (int s = 1; s < 4; s++)
      run_slot("R4 norm f1 idle", 16'h0, 1'b0, 1'b0, 0, 16'h0, 0, 16'h0);
    chk_state("R4 held word", 1'b0, 1'b0, 1'b0, 1'b0);
    run_slot("R12 norm f2s0", 16'h5B77, 1'b1, 1'b1, 0, 16'h0, 0, 16'h0);
    for (int s = 1; s < 4; s++)
      run_slot("R4 norm f2 idle", 16'h0, 1'b0, 1'b0, 0, 16'h0, 0, 16'h0);
    chk_state("R4 idle no underrun", 1'b1, 1'b0, 1'b1, 1'b0);
    run_slot("R6 norm resend", 16'h5B77, 1'b1, 1'b1, 0, 16'h0, 0, 16'h0);
    chk_state("R9 exception route", 1'b1, 1'b1, 1'b0, 1'b1);
    disable_tx();

    // single-slot network frames (R5, R10)
    net_mode = 1'b1; slots_m1 = 4'd0;
    pulse(2, 16'h0);
    pulse(1, 16'h6E19);
    chk("R7 read then write", {15'b0, stat_underrun}, 16'h0);
    tx_en = 1'b1;
    run_slot("R10 single a", 16'h6E19, 1'b1, 1'b1, 1, 16'hC0D5, 0, 16'h0);
    run_slot("R10 single b", 16'hC0D5, 1'b1, 1'b1, 0, 16'h0, 0, 16'h0);
    chk_state("R9 data route", 1'b1, 1'b0, 1'b1, 1'b0);
    disable_tx();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule